// File: doc/BRIEF.md
# Address Monitor Wait Controller

This block parks a processor thread in one of two low-power wait depths and wakes it on a defined event. Software first arms the monitor with an address. The block then watches every store address seen on a snoop port. A store that lands in the same 64-byte aligned block as the armed address triggers the monitor.

A wait command carries a 64-bit absolute deadline and a depth-select bit. There are two flavours of wait. A monitored wait ends on a monitor trigger or on the deadline. A timed pause ignores the monitor completely and ends only on time.

Two supervisor inputs constrain every wait. The first is an optional cap on how long any wait may last, counted in timestamp units. The second is a switch that forbids the deeper depth. On exit the block pulses a completion signal together with a 2-bit wake reason. A separate flag marks exits caused by the supervisor cap.

Top module: `monwait_ctrl`

## Requirements
- R1: An arm strobe latches bits [47:6] of the given address as the monitored block and places the monitor in the armed state; this clears any pending trigger.
- R2: While armed, a snooped store whose address bits [47:6] equal the latched block triggers the monitor; bits [5:0] are ignored, and a store to any other block has no effect.
- R3: A monitored wait ends after a trigger with reason code 0. A store sampled at clock edge N sets the trigger, and done rises after edge N+1.
- R4: A wait ends with reason code 1 at the first edge in the wait state where the timestamp is greater than or equal to the deadline, using an unsigned 64-bit compare. A deadline already passed ends the wait on the edge after entry.
- R5: While waiting, the pstate output is 1 (light) when operand bit 0 is 1, and 2 (deep) when operand bit 0 is 0. When not waiting, pstate is 0.
- R6: When the deep-disable input is 1 at entry, a request for the deep state enters the light state (pstate 1) instead.
- R7: A timed pause ignores the monitor. A pending or new trigger does not end it, and it ends only by deadline (reason 1) or by the cap (reason 2).
- R8: A nonzero cap L, sampled at entry together with the entry timestamp T0, ends the wait with reason 2 and limit_hit high at the edge where the timestamp reaches T0+L. A cap of 0 imposes no limit.
- R9: A monitored wait entered while the monitor is unarmed, or while a trigger is already pending, ends on the edge after entry with reason code 0.
- R10: A monitor trigger disarms the monitor. The end of a monitored wait clears both the armed state and any pending trigger.
- R11: done is a one-cycle pulse. When several wake causes hold on the same edge, the priority is monitor, then deadline, then cap. limit_hit is high only together with done and reason 2.
- R12: A wait command received while a wait is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_valid | input | 1 | Arm strobe |
| arm_addr | input | 48 | Address to monitor |
| snoop_valid | input | 1 | A store is observed this cycle |
| snoop_addr | input | 48 | Address of the observed store |
| tsc | input | 64 | Free-running timestamp |
| wait_valid | input | 1 | Wait command strobe |
| wait_pause | input | 1 | 1 = timed pause, 0 = monitored wait |
| wait_light | input | 1 | Operand bit 0: 1 = light, 0 = deep |
| wait_deadline | input | 64 | Absolute wake timestamp |
| cfg_limit | input | 32 | Supervisor cap in timestamp units, 0 = none |
| cfg_deep_dis | input | 1 | Supervisor forbids the deep state |
| busy | output | 1 | A wait is in progress |
| pstate | output | 2 | 0 active, 1 light, 2 deep |
| done | output | 1 | One-cycle wake pulse |
| reason | output | 2 | 0 monitor, 1 deadline, 2 cap; valid with done |
| limit_hit | output | 1 | Wake caused by the supervisor cap |

## Verification
Every wake result appears exactly one edge after the edge on which its cause is first visible in the wait state. A wait entered at the edge where the timestamp reads T0 therefore reports immediate completions two falling edges after the command is driven. A deadline D reports with the timestamp reading D+1, and a cap L reports with it reading T0+L+1. A store reports two falling edges after it is driven. The bench drives inputs and samples outputs on falling edges, and counts those edges or compares the timestamp observed at done against these exact values. Checks that something is ignored either hold the wait open and observe that done stays low, or observe the wake reason and time of the following wait.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

    typedef enum logic [1:0] {
        WAKE_MON      = 2'd0,
        WAKE_DEADLINE = 2'd1,
        WAKE_LIMIT    = 2'd2
    } wake_e;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_LIGHT  = 2'd1,
        PS_DEEP   = 2'd2
    } pstate_e;

    typedef enum logic {
        FSM_IDLE,
        FSM_PARKED
    } fsm_e;

    typedef struct packed {
        logic    pause;
        pstate_e depth;
    } wait_ctx_t;

    function automatic pstate_e pick_depth(input logic light_bit, input logic deep_forbid);
        return (light_bit || deep_forbid) ? PS_LIGHT : PS_DEEP;
    endfunction

    function automatic wake_e arbitrate(input logic mon, input logic dl, input logic lim);
        if (mon)
            return WAKE_MON;
        else if (dl)
            return WAKE_DEADLINE;
        else if (lim)
            return WAKE_LIMIT;
        else
            return WAKE_MON;
    endfunction

endpackage

// File: rtl/mwc_monitor.sv
module mwc_monitor #(
    parameter int ADDR_W  = 48,
    parameter int BLK_LG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_valid,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              clear,
    output logic              armed,
    output logic              fired
);
    localparam int TAG_W = ADDR_W - BLK_LG2;

    logic [TAG_W-1:0] tag_q;
    logic             hit;

    assign hit = snoop_valid && (snoop_addr[ADDR_W-1:BLK_LG2] == tag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            armed <= 1'b0;
            fired <= 1'b0;
        end else if (arm_valid) begin
            tag_q <= arm_addr[ADDR_W-1:BLK_LG2];
            armed <= 1'b1;
            fired <= 1'b0;
        end else if (clear) begin
            armed <= 1'b0;
            fired <= 1'b0;
        end else if (armed && hit) begin
            armed <= 1'b0;
            fired <= 1'b1;
        end
    end

    AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (clear && !arm_valid) |=> (!armed && !fired)); // R10
    AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(fired) |-> ($past(armed) && $past(snoop_valid))); // R2
    AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
        arm_valid |=> (armed && !fired)); // R1

endmodule

// File: rtl/mwc_timer.sv
module mwc_timer #(
    parameter int TS_W  = 64,
    parameter int LIM_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TS_W-1:0]  tsc,
    input  logic [TS_W-1:0]  deadline,
    input  logic [LIM_W-1:0] limit,
    output logic             dl_reached,
    output logic             lim_reached
);
    logic [TS_W-1:0] dl_q;
    logic [TS_W-1:0] lim_tgt_q;
    logic            lim_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dl_q      <= '0;
            lim_tgt_q <= '0;
            lim_en_q  <= 1'b0;
        end else if (load) begin
            dl_q      <= deadline;
            lim_tgt_q <= tsc + TS_W'(limit);
            lim_en_q  <= (limit != '0);
        end
    end

    assign dl_reached  = (tsc >= dl_q);
    assign lim_reached = lim_en_q && (tsc >= lim_tgt_q);

    AST_ZERO_CAP_OFF: assert property (@(posedge clk) disable iff (rst)
        (load && limit == '0) |=> !lim_reached); // R8

endmodule

// File: rtl/monwait_ctrl.sv
module monwait_ctrl
    import mwc_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int BLK_LG2 = 6,
    parameter int TS_W    = 64,
    parameter int LIM_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_valid,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [TS_W-1:0]   tsc,
    input  logic              wait_valid,
    input  logic              wait_pause,
    input  logic              wait_light,
    input  logic [TS_W-1:0]   wait_deadline,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              cfg_deep_dis,
    output logic              busy,
    output logic [1:0]        pstate,
    output logic              done,
    output logic [1:0]        reason,
    output logic              limit_hit
);
    fsm_e      state_q;
    wait_ctx_t ctx_q;
    wake_e     reason_q;
    wake_e     why;
    logic      done_q, limhit_q;
    logic      mon_armed, mon_fired, mon_clear;
    logic      dl_reached, lim_reached;
    logic      enter, mon_wake, wake;

    assign enter     = (state_q == FSM_IDLE) && wait_valid;
    assign mon_wake  = !ctx_q.pause && (mon_fired || !mon_armed);
    assign wake      = (state_q == FSM_PARKED) && (mon_wake || dl_reached || lim_reached);
    assign why       = arbitrate(mon_wake, dl_reached, lim_reached);
    assign mon_clear = wake && !ctx_q.pause;

    mwc_monitor #(.ADDR_W(ADDR_W), .BLK_LG2(BLK_LG2)) u_mon (
        .clk         (clk),
        .rst         (rst),
        .arm_valid   (arm_valid),
        .arm_addr    (arm_addr),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .clear       (mon_clear),
        .armed       (mon_armed),
        .fired       (mon_fired)
    );

    mwc_timer #(.TS_W(TS_W), .LIM_W(LIM_W)) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .load        (enter),
        .tsc         (tsc),
        .deadline    (wait_deadline),
        .limit       (cfg_limit),
        .dl_reached  (dl_reached),
        .lim_reached (lim_reached)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FSM_IDLE;
            ctx_q    <= '{pause: 1'b0, depth: PS_ACTIVE};
            reason_q <= WAKE_MON;
            done_q   <= 1'b0;
            limhit_q <= 1'b0;
        end else begin
            done_q   <= wake;
            limhit_q <= wake && (why == WAKE_LIMIT);
            if (enter) begin
                state_q <= FSM_PARKED;
                ctx_q   <= '{pause: wait_pause, depth: pick_depth(wait_light, cfg_deep_dis)};
            end else if (wake) begin
                state_q  <= FSM_IDLE;
                reason_q <= why;
            end
        end
    end

    assign busy      = (state_q == FSM_PARKED);
    assign pstate    = busy ? ctx_q.depth : PS_ACTIVE;
    assign done      = done_q;
    assign reason    = reason_q;
    assign limit_hit = limhit_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_LIMFLAG_ONLY_CAP: assert property (@(posedge clk) disable iff (rst)
        limit_hit |-> (done && reason == 2'd2)); // R11
    AST_DEEP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(cfg_deep_dis)) |-> (pstate != 2'd2)); // R6
    AST_IDLE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pstate == 2'd0)); // R5
    AST_PAUSE_NOT_MON: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && $past(ctx_q.pause) && done) |-> (reason != 2'd0)); // R7
    AST_DEADLINE_WAKE: assert property (@(posedge clk) disable iff (rst)
        (busy && dl_reached) |=> done); // R4

endmodule

// File: tb/monwait_ctrl_tb_top.sv
module monwait_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        arm_valid, snoop_valid, wait_valid;
    logic [47:0] arm_addr, snoop_addr;
    logic [63:0] tsc;
    logic        wait_pause, wait_light, cfg_deep_dis;
    logic [63:0] wait_deadline;
    logic [31:0] cfg_limit;
    logic        busy, done, limit_hit;
    logic [1:0]  pstate, reason;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [47:0] BLK_ADDR = 48'h1234_5678_9A45;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tsc <= 64'd0;
        else     tsc <= tsc + 64'd1;
    end

    monwait_ctrl dut_i (
        .clk(clk), .rst(rst),
        .arm_valid(arm_valid), .arm_addr(arm_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .tsc(tsc),
        .wait_valid(wait_valid), .wait_pause(wait_pause), .wait_light(wait_light),
        .wait_deadline(wait_deadline),
        .cfg_limit(cfg_limit), .cfg_deep_dis(cfg_deep_dis),
        .busy(busy), .pstate(pstate), .done(done), .reason(reason), .limit_hit(limit_hit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        arm_valid   = 1'b0;
        snoop_valid = 1'b0;
        wait_valid  = 1'b0;
    endtask

    task automatic do_arm(input logic [47:0] a);
        arm_valid = 1'b1; arm_addr = a;
        step();
    endtask

    task automatic set_store(input logic [47:0] a);
        snoop_valid = 1'b1; snoop_addr = a;
    endtask

    task automatic issue(input logic p, input logic light, input logic [63:0] dl, output logic [63:0] t0);
        wait_valid = 1'b1; wait_pause = p; wait_light = light; wait_deadline = dl;
        t0 = tsc;
    endtask

    task automatic wait_done(input int max, output int cnt, output logic [1:0] rsn,
                             output logic lh, output logic [63:0] tat);
        cnt = -1; rsn = 2'd3; lh = 1'b0; tat = 64'd0;
        for (int i = 1; i <= max; i++) begin
            step();
            if (done) begin
                cnt = i; rsn = reason; lh = limit_hit; tat = tsc;
                break;
            end
        end
    endtask

    task automatic t_reset();
        chk("R5 reset busy", busy, 0);
        chk("R5 reset pstate", pstate, 0);
        chk("R11 reset done", done, 0);
    endtask

    task automatic t_monitor_trigger();
        logic [63:0] t0, tat; int cnt; logic [1:0] r; logic lh;
        do_arm(BLK_ADDR);
        issue(1'b0, 1'b1, tsc + 64'd1000, t0);
        step();
        chk("R5 light pstate", pstate, 1);
        set_store(48'h1234_5678_9A80); step();
        set_store(48'h1234_5678_9A3F); step();
        step(); step();
        chk("R2 other block no wake busy", busy, 1);
        set_store(48'h1234_5678_9A7F);
        wait_done(10, cnt, r, lh, tat);
        chk("R3 trigger latency", cnt, 2);
        chk("R3 trigger reason", r, 0);
        chk("R1 same block other offset", lh, 0);
    endtask

    task automatic t_deadline();
        logic [63:0] t0, tat; int cnt; logic [1:0] r; logic lh;
        issue(1'b1, 1'b0, tsc + 64'd10, t0);
        step();
        chk("R5 deep pstate", pstate, 2);
        wait_done(50, cnt, r, lh, tat);
        chk("R4 deadline reason", r, 1);
        chk("R4 deadline time", tat, t0 + 64'd11);
        do_arm(BLK_ADDR);
        issue(1'b0, 1'b1, tsc + 64'd7, t0);
        wait_done(50, cnt, r, lh, tat);
        chk("R4 armed wait deadline reason", r, 1);
        chk("R4 armed wait deadline time", tat, t0 + 64'd8);
        issue(1'b1, 1'b1, 64'd0, t0);
        wait_done(50, cnt, r, lh, tat);
        chk("R4 past deadline latency", cnt, 2);
        chk("R4 past deadline reason", r, 1);
    endtask

    task automatic t_deep_forbid();
        logic [63:0] t0, tat; int cnt; logic [1:0] r; logic lh;
        cfg_deep_dis = 1'b1;
        issue(1'b1, 1'b0, tsc + 64'd6, t0);
        step();
        chk("R6 deep forbidden pstate", pstate, 1);
        wait_done(50, cnt, r, lh, tat);
        chk("R5 idle pstate after wake", pstate, 0);
        cfg_deep_dis = 1'b0;
    endtask

    task automatic t_pause_ignores_monitor();
        logic [63:0] t0, tat; int cnt; logic [1:0] r; logic lh;
        do_arm(BLK_ADDR);
        set_store(BLK_ADDR); step();
        issue(1'b1, 1'b1, tsc + 64'd8, t0);
        step();
        set_store(BLK_ADDR);
        wait_done(50, cnt, r, lh, tat);
        chk("R7 pause reason", r, 1);
        chk("R7 pause time", tat, t0 + 64'd9);
        issue(1'b0, 1'b1, tsc + 64'd500, t0);
        wait_done(50, cnt, r, lh, tat);
        chk("R9 pending trigger latency", cnt, 2);
        chk("R9 pending trigger reason", r, 0);
    endtask

    task automatic t_unarmed_and_disarm();
        logic [63:0] t0, tat; int cnt; logic [1:0] r; logic lh;
        issue(1'b0, 1'b0, tsc + 64'd500, t0);
        wait_done(50, cnt, r, lh, tat);
        chk("R9 unarmed latency", cnt, 2);
        chk("R9 unarmed reason", r, 0);
        do_arm(BLK_ADDR);
        issue(1'b0, 1'b1, tsc + 64'd500, t0);
        step();
        set_store(BLK_ADDR);
        wait_done(50, cnt, r, lh, tat);
        chk("R10 trigger wake reason", r, 0);
        issue(1'b0, 1'b1, tsc + 64'd15, t0);
        wait_done(50, cnt, r, lh, tat);
        chk("R10 disarmed after wake latency", cnt, 2);
        chk("R10 disarmed after wake reason", r, 0);
    endtask

    task automatic t_limit();
        logic [63:0] t0, tat; int cnt; logic [1:0] r; logic lh;
        cfg_limit = 32'd5;
        issue(1'b1, 1'b1, tsc + 64'd1000, t0);
        wait_done(50, cnt, r, lh, tat);
        chk("R8 cap reason", r, 2);
        chk("R8 cap flag", lh, 1);
        chk("R8 cap time", tat, t0 + 64'd6);
        cfg_limit = 32'd0;
        issue(1'b1, 1'b1, tsc + 64'd30, t0);
        wait_done(100, cnt, r, lh, tat);
        chk("R8 zero cap reason", r, 1);
        chk("R8 zero cap flag", lh, 0);
        chk("R8 zero cap time", tat, t0 + 64'd31);
    endtask

    task automatic t_priority_pulse();
        logic [63:0] t0, tat; int cnt; logic [1:0] r; logic lh;
        cfg_limit = 32'd9;
        issue(1'b1, 1'b1, tsc + 64'd9, t0);
        wait_done(50, cnt, r, lh, tat);
        chk("R11 deadline over cap reason", r, 1);
        chk("R11 no cap flag", lh, 0);
        step();
        chk("R11 done single cycle", done, 0);
        cfg_limit = 32'd0;
    endtask

    task automatic t_busy_ignores();
        logic [63:0] t0, t1, tat; int cnt; logic [1:0] r; logic lh;
        issue(1'b1, 1'b1, tsc + 64'd12, t0);
        step();
        issue(1'b1, 1'b1, 64'd0, t1);
        wait_done(50, cnt, r, lh, tat);
        chk("R12 second command ignored time", tat, t0 + 64'd13);
        step(); step();
        chk("R12 no re-entry", busy, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        arm_valid = 0; snoop_valid = 0; wait_valid = 0;
        arm_addr = '0; snoop_addr = '0; wait_pause = 0; wait_light = 0;
        wait_deadline = '0; cfg_limit = '0; cfg_deep_dis = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_monitor_trigger();
        t_deadline();
        t_deep_forbid();
        t_pause_ignores_monitor();
        t_unarmed_and_disarm();
        t_limit();
        t_priority_pulse();
        t_busy_ignores();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule